// File: doc/BRIEF.md
# Shadow Register Update Controller

This block keeps two copies of a small set of display and layer configuration words. Software writes a staging copy at any time. The raster logic only ever sees an active copy. The active copy takes the staging contents only at a frame boundary, which is marked by a one-cycle frame-start pulse from the timing generator. So a configuration is never half applied in the middle of a picture.

An update-mode register controls when the transfer happens. The top bit selects automatic mode, in which every frame boundary loads the active copy. The bit below it is a one-shot request: software sets it, and the next frame boundary makes exactly one transfer. The bit keeps reading 1 until that transfer has happened, so a driver can poll it to learn when new settings are live. The configuration words sit at word addresses 0 to NUM_WORDS-1. The update-mode register sits at address NUM_WORDS. Reads of configuration words return the staging value.

Top module: `shadow_update_ctrl`

## Requirements
- R1: After a synchronous reset, all staging words, all active words, `active_load` and the update-mode register are zero.
- R2: A write to word address i (below NUM_WORDS) updates only staging word i. A read of that address returns the staging value. The active words do not change until a transfer occurs.
- R3: Writing the update-mode register with bit 30 = 1 arms a one-shot request. The next frame-start pulse copies every staging word to the active words, and later pulses make no further copy unless the request is armed again.
- R4: Bit 30 reads back as 1 from the write until one clock after the copy, then reads 0. Writing the register with bit 30 = 0 does not cancel a pending request.
- R5: Bit 31 of the update-mode register selects automatic mode and reads back as written. While it is 1, every frame-start pulse copies staging to active.
- R6: A copy happens only on a clock edge where `frame_start` is high. `active_load` is high for exactly the one cycle after each copy edge, and then the new active values are visible.
- R7: When a request is pending and automatic mode is on at the same frame pulse, one copy is made and the request still clears one clock later.
- R8: A write that lands on the same edge as a frame-start pulse is not part of that frame's copy. A configuration word written then goes live at the next copy. A request armed then waits for the next pulse.
- R9: Addresses above NUM_WORDS are not decoded. Writes to them change no staging word and no mode bit, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle frame boundary pulse (vertical blanking) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| active_words | output | NUM_WORDS*DATA_W | Active configuration words; word i in bits [i*DATA_W +: DATA_W] |
| active_load | output | 1 | High for one cycle after the active words were loaded |

## Verification
The assertions take `frame_start` to be a single-cycle pulse that is separated from the next pulse by at least two idle cycles. They also assume that a new request is not written in the clock right after a request-driven copy. The property that ties a falling request bit to a copy two cycles earlier relies on this. The stimulus follows these rules by running each frame task for three cycles: the pulse cycle, then one cycle in which the request bit is still high, then one cycle in which it has cleared. Writes in the same cycle as a frame pulse are made only through that task.

// File: rtl/shadow_pkg.sv
`timescale 1ns/1ps
package shadow_pkg;

    // Address classes of the register window
    typedef enum logic [1:0] {
        ADR_WORD = 2'd0,
        ADR_CTRL = 2'd1,
        ADR_NONE = 2'd2
    } adr_kind_e;

    // Update-mode register state
    typedef struct packed {
        logic auto_mode;
        logic req;
    } upd_ctrl_t;

    function automatic adr_kind_e decode_addr(input int unsigned addr,
                                              input int unsigned num_words);
        if (addr < num_words)
            return ADR_WORD;
        else if (addr == num_words)
            return ADR_CTRL;
        return ADR_NONE;
    endfunction

endpackage

// File: rtl/shadow_bank.sv
`timescale 1ns/1ps
module shadow_bank #(
    parameter int NUM_WORDS = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        copy_en,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_WORDS*DATA_W-1:0] active_flat
);

    logic [DATA_W-1:0] staging [NUM_WORDS];
    logic [DATA_W-1:0] active  [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                staging[g] <= '0;
                active[g]  <= '0;
            end else begin
                // copy samples the staging value held before this edge
                if (copy_en)
                    active[g] <= staging[g];
                if (wr_en && (32'(wr_idx) == g))
                    staging[g] <= wr_data;
            end
        end
        assign active_flat[g*DATA_W +: DATA_W] = active[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WORDS; i++)
            if (32'(rd_idx) == i)
                rd_data = staging[i];
    end

    // R2: the active words only change across a copy edge
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !copy_en |=> $stable(active_flat))
        else $error("p_hold_r2: active words changed without a copy");

endmodule

// File: rtl/shadow_seq.sv
`timescale 1ns/1ps
module shadow_seq
    import shadow_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_wdata,
    output logic              copy_en,
    output upd_ctrl_t         ctrl_q
);

    localparam int AUTO_BIT = DATA_W - 1;
    localparam int REQ_BIT  = DATA_W - 2;

    logic clr_pend;
    logic set_req;

    assign set_req = ctrl_wr & ctrl_wdata[REQ_BIT];
    assign copy_en = frame_start & (ctrl_q.auto_mode | (ctrl_q.req & ~clr_pend));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            clr_pend <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl_q.auto_mode <= ctrl_wdata[AUTO_BIT];
            if (set_req)
                ctrl_q.req <= 1'b1;
            else if (clr_pend)
                ctrl_q.req <= 1'b0;
            // a request armed on the copy edge survives for the next frame
            clr_pend <= copy_en & ctrl_q.req & ~clr_pend & ~set_req;
        end
    end

    // R5: automatic mode copies on every frame pulse
    p_auto_copy_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_start && ctrl_q.auto_mode) |-> copy_en)
        else $error("p_auto_copy_r5: frame pulse in auto mode made no copy");

    // R4: the request still reads 1 in the cycle after its copy
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (copy_en && ctrl_q.req && !clr_pend) |=> ctrl_q.req)
        else $error("p_req_hold_r4: request cleared on the copy edge");

    // R4: a request only falls one clock after a copy
    p_req_clear_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.req) |-> $past(copy_en, 2))
        else $error("p_req_clear_r4: request cleared without a copy");

endmodule

// File: rtl/shadow_update_ctrl.sv
`timescale 1ns/1ps
module shadow_update_ctrl
    import shadow_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        frame_start,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [NUM_WORDS*DATA_W-1:0] active_words,
    output logic                        active_load
);

    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    adr_kind_e         kind;
    logic              copy_en;
    upd_ctrl_t         ctrl_q;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] word_rd;

    assign kind = decode_addr(32'(bus_addr), NUM_WORDS);
    assign idx  = bus_addr[IDX_W-1:0];

    shadow_bank #(
        .NUM_WORDS (NUM_WORDS),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (bus_wr && (kind == ADR_WORD)),
        .wr_idx      (idx),
        .wr_data     (bus_wdata),
        .copy_en     (copy_en),
        .rd_idx      (idx),
        .rd_data     (word_rd),
        .active_flat (active_words)
    );

    shadow_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .ctrl_wr     (bus_wr && (kind == ADR_CTRL)),
        .ctrl_wdata  (bus_wdata),
        .copy_en     (copy_en),
        .ctrl_q      (ctrl_q)
    );

    always_comb begin
        unique case (kind)
            ADR_WORD: bus_rdata = word_rd;
            ADR_CTRL: bus_rdata = {ctrl_q.auto_mode, ctrl_q.req, {(DATA_W-2){1'b0}}};
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            active_load <= 1'b0;
        else
            active_load <= copy_en;
    end

    // R6: a load is only ever reported after a frame pulse
    p_frame_only_r6: assert property (@(posedge clk) disable iff (rst)
        active_load |-> $past(frame_start))
        else $error("p_frame_only_r6: load outside a frame boundary");

endmodule

// File: tb/shadow_update_ctrl_bench.sv
`timescale 1ns/1ps
module shadow_update_ctrl_bench;

    localparam int N  = 4;
    localparam int W  = 32;
    localparam int AW = 4;
    localparam int CTRL = N;

    typedef struct {
        int          kind;   // 0 active word, 1 read data, 2 load pulse
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [N*W-1:0] active_words;
    logic active_load;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    item_t q[$];

    logic [31:0] stg_m [N];
    logic [31:0] act_m [N];
    bit auto_m, req_m;

    always #2 clk = ~clk;

    shadow_update_ctrl #(.NUM_WORDS(N), .DATA_W(W), .ADDR_W(AW)) u_shadow_update_ctrl (
        .clk (clk), .rst (rst), .frame_start (frame_start),
        .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .active_words (active_words),
        .active_load (active_load)
    );

    // monitor: pops expected items and compares mid-cycle
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = active_words[it.idx*W +: W];
                1:       act = bus_rdata;
                default: act = {31'd0, active_load};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                         it.req, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic push(int kind, int idx, logic [31:0] exp, string r);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = r;
        q.push_back(it);
    endtask

    function automatic logic [31:0] ctrl_val(bit a, bit rq);
        return {a, rq, 30'd0};
    endfunction

    task automatic model_wr(int addr, logic [31:0] d);
        if (addr < N) stg_m[addr] = d;
        else if (addr == CTRL) begin
            auto_m = d[31];
            if (d[30]) req_m = 1;
        end
    endtask

    task automatic wr(int addr, logic [31:0] d);
        bus_wr = 1; bus_addr = AW'(addr); bus_wdata = d;
        step();
        bus_wr = 0;
        model_wr(addr, d);
    endtask

    // read check in the current cycle, then advance
    task automatic chk_rd(int addr, logic [31:0] exp, string r);
        bus_addr = AW'(addr);
        push(1, addr, exp, r);
        step();
    endtask

    task automatic chk_act(string r);
        for (int i = 0; i < N; i++) push(0, i, act_m[i], r);
    endtask

    // frame pulse, optionally with a write on the same edge
    task automatic frame(bit do_wr, int addr, logic [31:0] d, string r);
        bit copy, had_req, new_set;
        copy = auto_m || req_m;
        had_req = req_m;
        new_set = do_wr && (addr == CTRL) && d[30];
        frame_start = 1;
        if (do_wr) begin bus_wr = 1; bus_addr = AW'(addr); bus_wdata = d; end
        step();
        frame_start = 0; bus_wr = 0;
        if (copy) for (int i = 0; i < N; i++) act_m[i] = stg_m[i];
        if (do_wr) model_wr(addr, d);
        push(2, 0, {31'd0, copy}, r);
        chk_act(r);
        chk_rd(CTRL, ctrl_val(auto_m, req_m), r);
        if (had_req && copy && !new_set) req_m = 0;
        push(2, 0, 32'd0, r);
        chk_act(r);
        chk_rd(CTRL, ctrl_val(auto_m, req_m), r);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin stg_m[i] = '0; act_m[i] = '0; end
        auto_m = 0; req_m = 0;
        repeat (3) step();
        rst = 0;
        step();

        // R1: reset state
        push(2, 0, 32'd0, "R1");
        chk_act("R1");
        chk_rd(CTRL, 32'd0, "R1");
        for (int i = 0; i < N; i++) chk_rd(i, 32'd0, "R1");

        // R2: staging writes read back, active unchanged
        for (int i = 0; i < N; i++) wr(i, 32'hA000_0000 + 32'(i) * 32'h111);
        for (int i = 0; i < N; i++) chk_rd(i, stg_m[i], "R2");
        chk_act("R2");
        repeat (3) step();
        chk_act("R2");
        // R6: frame without request or auto makes no copy
        frame(0, 0, 0, "R6");

        // R3/R4: one-shot request
        wr(CTRL, 32'h4000_0000);
        chk_rd(CTRL, 32'h4000_0000, "R4");
        repeat (5) step();
        chk_act("R6");
        frame(0, 0, 0, "R3");
        wr(1, 32'h1234_5678);
        frame(0, 0, 0, "R3");
        chk_rd(1, 32'h1234_5678, "R2");

        // R4: writing 0 to the request bit does not cancel it
        wr(CTRL, 32'h4000_0000);
        wr(CTRL, 32'h0000_0000);
        chk_rd(CTRL, 32'h4000_0000, "R4");
        frame(0, 0, 0, "R4");

        // R5: automatic mode
        wr(CTRL, 32'h8000_0000);
        chk_rd(CTRL, 32'h8000_0000, "R5");
        wr(0, 32'h0BAD_F00D);
        frame(0, 0, 0, "R5");
        wr(3, 32'hFFFF_0001);
        frame(0, 0, 0, "R5");

        // R7: request together with auto
        wr(2, 32'h5555_AAAA);
        wr(CTRL, 32'hC000_0000);
        chk_rd(CTRL, 32'hC000_0000, "R7");
        frame(0, 0, 0, "R7");

        // R8: word written on the copy edge misses that copy
        frame(1, 2, 32'h7777_0002, "R8");
        frame(0, 0, 0, "R8");
        // R8: request armed on the frame edge waits for the next pulse
        wr(CTRL, 32'h0000_0000);
        wr(1, 32'h0101_0101);
        frame(1, CTRL, 32'h4000_0000, "R8");
        frame(0, 0, 0, "R8");

        // R9: undecoded addresses
        wr(CTRL + 1, 32'hDEAD_BEEF);
        wr(15, 32'hFFFF_FFFF);
        chk_rd(CTRL + 1, 32'd0, "R9");
        chk_rd(15, 32'd0, "R9");
        chk_rd(CTRL, ctrl_val(auto_m, req_m), "R9");
        for (int i = 0; i < N; i++) chk_rd(i, stg_m[i], "R9");
        frame(0, 0, 0, "R9");

        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule